// File: doc/BRIEF.md
# Sliding ternary overlap matcher

This block decides how much of the current scan-chain content can be kept as part of the next scan-in stimulus. A binary reuse vector is compared with a ternary pattern in which each position is 0, 1 or don't-care. The reuse vector holds either the captured response or the previous stimulus. The chain is moved toward the scan-out end one bit per step, and the search begins at a supplied pre-shift count. At each step the bits that remain in the chain are compared with the leading part of the pattern. The first count that is compatible ends the search. That count is reported together with the number of scan clocks it saves.

Bit 0 of every vector is the position nearest the scan-out pin. After k shifts, chain bit k+j sits in position j, and positions N-k and above have been vacated. A request is made with a single-cycle start pulse. The block then tests one shift count per clock and raises done for one cycle with the result. The result stays on the outputs until the next request completes.

Top module: `slide_overlap_match`

## Requirements
- R1: A pattern position with care_i[j]=0 is don't-care and always compatible. With care_i[j]=1 it is compatible only when value_i[j] equals the chain bit placed in position j.
- R2: For shift count k, pattern position j (j < N-k) is compared with reuse_i[j+k]. Positions j >= N-k are not checked. A count is compatible only when every checked position is compatible.
- R3: The search tests counts preshift_i, preshift_i+1, ... up to N-1. Counts below preshift_i are never reported.
- R4: When a compatible count exists, the smallest one k is reported with match_o=1, shift_o=k and saved_o=N-k.
- R5: When no count from preshift_i to N-1 is compatible, the block reports match_o=0, shift_o=N and saved_o=0.
- R6: A preshift_i of N or more gives the no-match result of R5 on the clock after the start is taken.
- R7: A start_i sampled while idle sets busy_o on the next clock. done_o rises L clocks after the start is taken, where L = k-preshift_i+1 on a match, N-preshift_i on no match with preshift_i < N, and 1 otherwise. busy_o is high in between and never together with done_o.
- R8: done_o is high for exactly one clock. match_o, shift_o and saved_o change only in the cycle where done_o rises and hold their values afterwards.
- R9: start_i and the data inputs are ignored while busy_o is high. The running search finishes with the operands captured at its own start.
- R10: After reset, busy_o, done_o, match_o, shift_o and saved_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only while idle |
| reuse_i | input | N | Binary chain content, bit 0 nearest scan-out |
| care_i | input | N | Pattern care bits, 0 means don't-care |
| value_i | input | N | Pattern values for cared positions |
| preshift_i | input | CW | First shift count to try (CW = clog2(N+1)+1) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| match_o | output | 1 | A compatible shift count was found |
| shift_o | output | CW | Reported shift count |
| saved_o | output | CW | Scan clocks saved |

## Verification
The bench builds the block with N=4, so CW is 4 bits. At this size every binary chain value (16), every ternary pattern (81) and every pre-shift count from 0 to 6 can be swept, including counts equal to and above N. Every partial window, every mix of don't-care positions and every first-match position is therefore exercised against an arithmetic model. The exact cycle of the done strobe and the held outputs are checked on each run. A directed run sends a second request during a search.

// File: rtl/slide_overlap_pkg.sv
package slide_overlap_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } ovl_state_e;
endpackage

// File: rtl/slide_window_compat.sv
module slide_window_compat #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1) + 1
) (
  input  logic [N-1:0]  reuse_i,
  input  logic [N-1:0]  care_i,
  input  logic [N-1:0]  value_i,
  input  logic [CW-1:0] shift_i,
  output logic          hit_o
);
  logic [N-1:0] shifted;
  logic [N-1:0] pos_ok;

  assign shifted = reuse_i >> shift_i;

  // vacated positions and don't-care symbols always pass
  for (genvar j = 0; j < N; j++) begin : g_pos
    assign pos_ok[j] = ((int'(shift_i) + j) >= N) | ~care_i[j] |
                       (value_i[j] == shifted[j]);
  end

  assign hit_o = &pos_ok;
endmodule

// File: rtl/slide_search_ctrl.sv
module slide_search_ctrl
  import slide_overlap_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] preshift_i,
  input  logic          hit_i,
  output logic [CW-1:0] try_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          match_o,
  output logic [CW-1:0] shift_o,
  output logic [CW-1:0] saved_o
);
  localparam logic [CW-1:0] FULL = CW'(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  ovl_state_e    state_q;
  logic [CW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      done_o  <= 1'b0;
      match_o <= 1'b0;
      shift_o <= '0;
      saved_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            k_q     <= preshift_i;
            state_q <= ST_SCAN;
          end
        end
        default: begin
          if (k_q < FULL && hit_i) begin
            match_o <= 1'b1;
            shift_o <= k_q;
            saved_o <= FULL - k_q;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (k_q >= LAST) begin
            match_o <= 1'b0;
            shift_o <= FULL;
            saved_o <= '0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign try_o  = k_q;
  assign busy_o = (state_q == ST_SCAN);
endmodule

// File: rtl/slide_overlap_match.sv
module slide_overlap_match #(
  parameter int N  = 16,
  localparam int CW = $clog2(N + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  reuse_i,
  input  logic [N-1:0]  care_i,
  input  logic [N-1:0]  value_i,
  input  logic [CW-1:0] preshift_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          match_o,
  output logic [CW-1:0] shift_o,
  output logic [CW-1:0] saved_o
);
  logic [N-1:0]  reuse_q, care_q, value_q;
  logic [CW-1:0] try_k;
  logic          hit;

  // operands frozen for the whole search
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reuse_q <= '0;
      care_q  <= '0;
      value_q <= '0;
    end else if (start_i && !busy_o) begin
      reuse_q <= reuse_i;
      care_q  <= care_i;
      value_q <= value_i;
    end
  end

  slide_window_compat #(.N(N), .CW(CW)) u_compat (
    .reuse_i (reuse_q),
    .care_i  (care_q),
    .value_i (value_q),
    .shift_i (try_k),
    .hit_o   (hit)
  );

  slide_search_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .preshift_i (preshift_i),
    .hit_i      (hit),
    .try_o      (try_k),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .match_o    (match_o),
    .shift_o    (shift_o),
    .saved_o    (saved_o)
  );
endmodule

// File: rtl/slide_overlap_match_chk.sv
module slide_overlap_match_chk #(
  parameter int N  = 16,
  localparam int CW = $clog2(N + 1) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          match_o,
  input logic [CW-1:0] shift_o,
  input logic [CW-1:0] saved_o
);
  localparam logic [CW-1:0] FULL = CW'(N);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({match_o, shift_o, saved_o}));

  assert_busy_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> busy_o);

  assert_no_match_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !match_o) |-> (saved_o == '0 && shift_o == FULL));

  assert_match_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && match_o) |-> (shift_o < FULL && saved_o != '0));
endmodule

bind slide_overlap_match slide_overlap_match_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .match_o (match_o),
  .shift_o (shift_o),
  .saved_o (saved_o)
);

// File: tb/slide_overlap_match_test.sv
`timescale 1ns/1ps
module slide_overlap_match_test;
  localparam int N  = 4;
  localparam int CW = $clog2(N + 1) + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  reuse_i = '0, care_i = '0, value_i = '0;
  logic [CW-1:0] preshift_i = '0;
  logic          busy_o, done_o, match_o;
  logic [CW-1:0] shift_o, saved_o;

  int nchk = 0;
  int nerr = 0;

  always #5 clk_i = ~clk_i;

  slide_overlap_match #(.N(N)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model built from R1..R7
  task automatic model(input logic [N-1:0] r, c, v, input int pre,
                       output bit m, output int k_out, output int lat);
    m = 0;
    k_out = N;
    lat = (pre >= N) ? 1 : N - pre;
    for (int k = pre; k < N; k++) begin
      bit ok = 1;
      for (int j = 0; j < N - k; j++)
        if (c[j] && (v[j] != r[j + k])) ok = 0;
      if (ok && !m) begin
        m = 1;
        k_out = k;
        lat = k - pre + 1;
      end
    end
  endtask

  task automatic run(input logic [N-1:0] r, c, v, input int pre, input bit inject);
    bit m;
    int ek, el, cyc;
    model(r, c, v, pre, m, ek, el);
    @(negedge clk_i);
    reuse_i = r; care_i = c; value_i = v; preshift_i = CW'(pre);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (inject) begin
      chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
      // competing request that would match at once
      reuse_i = '0; care_i = '0; value_i = '0; preshift_i = '0;
      start_i = 1'b1;
    end
    cyc = 0;
    while (!done_o && cyc < 20) begin
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    if (m) begin
      chk(cyc == el, "R3,R7 latency match", cyc, el);
      chk(match_o == 1'b1, "R1,R2,R4 match flag", match_o, 1);
      chk(int'(shift_o) == ek, "R2,R3,R4 shift", shift_o, ek);
      chk(int'(saved_o) == N - ek, "R4 saved", saved_o, N - ek);
    end else begin
      chk(cyc == el, (pre >= N) ? "R6,R7 latency" : "R7 latency nomatch", cyc, el);
      chk(match_o == 1'b0, (pre >= N) ? "R6 match flag" : "R1,R2,R5 match flag", match_o, 0);
      chk(int'(shift_o) == N, "R5 shift", shift_o, N);
      chk(saved_o == '0, "R5 saved", saved_o, 0);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done pulse", done_o, 0);
    chk(busy_o == 1'b0, "R7 idle after done", busy_o, 0);
    chk(int'(shift_o) == ek, "R8 shift held", shift_o, ek);
  endtask

  initial begin
    #1;
    chk(busy_o == 0 && done_o == 0, "R10 reset busy/done", {busy_o, done_o}, 0);
    chk(match_o == 0 && shift_o == 0 && saved_o == 0, "R10 reset result",
        {match_o, shift_o, saved_o}, 0);
    #24 rst_ni = 1'b1;

    // R9: second request during a no-match search is ignored
    run(4'b0000, 4'b1111, 4'b1111, 0, 1'b1);

    for (int r = 0; r < 16; r++)
      for (int p = 0; p < 81; p++)
        for (int pre = 0; pre < 7; pre++) begin
          logic [N-1:0] c, v;
          int d = p;
          for (int j = 0; j < N; j++) begin
            c[j] = (d % 3) != 0;
            v[j] = (d % 3) == 2;
            d = d / 3;
          end
          run(N'(r), c, v, pre, 1'b0);
        end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule